// File: doc/BRIEF.md
# Serial Port Core with Line Status and Modem Control

This block is a byte-wide asynchronous serial transmitter and receiver with a small register interface. Software writes a byte to the data address. The byte waits in a one-entry holding register until the transmit shift engine is free, and the engine then sends it as a frame: one start bit, eight data bits with the least significant bit first, an even parity bit when `PARITY_EN` is set, and one stop bit. Each bit lasts `OVS` pulses of the `baud_tick` input. The receiver watches the serial input at the same oversampling rate. It confirms a start bit at mid-bit, samples every later bit at mid-bit, and places each finished byte in a one-entry receive buffer.

An 8-bit line status register reports the state of both directions. It shows whether the transmitter is fully drained, whether the holding register is free, and whether a byte is waiting to be read. It also holds four sticky error flags: break, framing, parity and overrun. Reading the line status register clears the four error flags. Reading the receive buffer clears the data-ready flag.

An 8-bit modem control register drives two active-low handshake outputs. It also selects loopback. In loopback the serial output pin stays high, and the transmitted frame goes straight to the receiver.

Top module: `uart_lsr_core`

## Requirements
- R1: The register addresses are 0 for data (a write fills the holding register, a read returns the receive buffer), 1 for modem control and 2 for line status. Address 3 reads as 0x00. Modem control resets to 0x00, and only bits 4, 1 and 0 are stored. All other bits of modem control read back as 0.
- R2: `rts_n` is the inverse of modem control bit 1 and `dtr_n` is the inverse of bit 0. Both outputs are 1 after reset.
- R3: Line status resets to 0x60. Its bits are: bit 7 always 0, bit 6 transmitter empty, bit 5 holding register empty, bit 4 break, bit 3 framing error, bit 2 parity error, bit 1 overrun, bit 0 data ready.
- R4: Holding-empty (bit 5) clears on a write to the data address and sets again when the shift engine takes the byte. Transmitter-empty (bit 6) is 1 only when both the holding register and the shift engine are empty.
- R5: A byte in the holding register is loaded on the first clock edge at which the shift engine is idle, and `tx_out` goes low from that edge. The frame is start 0, data LSB first, even parity (so that the data plus parity bit hold an even number of ones), then stop 1. Each bit ends on the clock edge of its 16th `baud_tick`, and the line stays 1 while idle.
- R6: While modem control bit 4 is set, `tx_out` is held at 1, `rx_in` is ignored, and the transmitted frame is received as if it had arrived on `rx_in`.
- R7: A received frame puts its byte in the receive buffer and sets data ready. The start bit must still be low at its mid-point, or the receiver returns to idle.
- R8: A read of the data address clears data ready, unless a new byte completes in the same cycle.
- R9: If a byte completes while data ready is set and the buffer is not read in that cycle, overrun sets. The buffer then holds the newer byte.
- R10: Framing error sets when the stop bit is sampled as 0. Parity error sets when the received parity bit differs from the even parity of the received data.
- R11: Break sets when the serial input stays low for more than 176 baud ticks, which is the length of a full frame with parity. The flag sets once for each low period.
- R12: A read of line status clears break, framing, parity and overrun. An error event in the same cycle as the read leaves its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse at OVS times the bit rate |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; read side effects take effect at the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| rx_in | input | 1 | Serial input, idle high |
| tx_out | output | 1 | Serial output, idle high |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Terminal-ready, active low |

## Verification
The assertions check the register-level rules on every cycle: the line stays high whenever the transmitter is idle or in loopback, the handshake outputs follow each modem-control write, and data ready and the error flags clear on the reads that own them. The assertions also check that an error event on the same cycle as a status read leaves its flag set, and that overrun, break and framing events land in their flags. Only the bench scenarios can show the serial framing and its timing. The bench compares `tx_out` with a queue-based frame model on every clock, and it drives receive frames with bad parity, a short invalid stop bit, back-to-back unread bytes and a long break. It also confirms that a looped-back byte arrives intact while `rx_in` is held low.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;

    localparam int DATA_W = 8;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_MCR  = 2'd1;
    localparam logic [1:0] ADDR_LSR  = 2'd2;

    localparam int MCR_LOOP = 4;
    localparam int MCR_RTS  = 1;
    localparam int MCR_DTR  = 0;
    localparam logic [7:0] MCR_MASK = 8'h13;

    typedef enum logic [2:0] {
        SER_IDLE,
        SER_START,
        SER_DATA,
        SER_PAR,
        SER_STOP
    } ser_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              fe;
        logic              pe;
    } rx_frame_t;

    typedef struct packed {
        logic bi;
        logic fe;
        logic pe;
        logic oe;
    } err_flags_t;

    function automatic logic even_par(input logic [DATA_W-1:0] d);
        return ^d;
    endfunction

endpackage

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
    import uart_lsr_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int PARITY_EN = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              busy,
    output logic              line
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(DATA_W);

    ser_state_e        state;
    logic [CW-1:0]     tcnt;
    logic [BW-1:0]     bitn;
    logic [DATA_W-1:0] shreg;
    logic              par_q;

    assign busy = (state != SER_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SER_IDLE;
            tcnt  <= '0;
            bitn  <= '0;
            shreg <= '0;
            par_q <= 1'b0;
            line  <= 1'b1;
        end else if (state == SER_IDLE) begin
            if (load) begin
                state <= SER_START;
                shreg <= load_data;
                par_q <= even_par(load_data);
                tcnt  <= '0;
                line  <= 1'b0;
            end
        end else if (tick) begin
            if (tcnt == CW'(OVS - 1)) begin
                tcnt <= '0;
                case (state)
                    SER_START: begin
                        state <= SER_DATA;
                        bitn  <= '0;
                        line  <= shreg[0];
                    end
                    SER_DATA: begin
                        if (bitn == BW'(DATA_W - 1)) begin
                            if (PARITY_EN != 0) begin
                                state <= SER_PAR;
                                line  <= par_q;
                            end else begin
                                state <= SER_STOP;
                                line  <= 1'b1;
                            end
                        end else begin
                            bitn  <= bitn + 1'b1;
                            shreg <= shreg >> 1;
                            line  <= shreg[1];
                        end
                    end
                    SER_PAR: begin
                        state <= SER_STOP;
                        line  <= 1'b1;
                    end
                    default: begin
                        state <= SER_IDLE;
                        line  <= 1'b1;
                    end
                endcase
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
    import uart_lsr_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int PARITY_EN = 1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      line,
    output logic      done,
    output rx_frame_t frame
);
    localparam int CW   = $clog2(OVS);
    localparam int BW   = $clog2(DATA_W);
    localparam int HALF = OVS / 2;

    ser_state_e        state;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     bitn;
    logic [DATA_W-1:0] shreg;
    logic              parbit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SER_IDLE;
            cnt    <= '0;
            bitn   <= '0;
            shreg  <= '0;
            parbit <= 1'b0;
            done   <= 1'b0;
            frame  <= '0;
        end else begin
            done <= 1'b0;
            if (state == SER_IDLE) begin
                if (!line) begin
                    state <= SER_START;
                    cnt   <= '0;
                end
            end else if (tick) begin
                if (state == SER_START) begin
                    if (cnt == CW'(HALF - 1)) begin
                        cnt   <= '0;
                        bitn  <= '0;
                        state <= line ? SER_IDLE : SER_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end else if (cnt == CW'(OVS - 1)) begin
                    cnt <= '0;
                    case (state)
                        SER_DATA: begin
                            shreg <= {line, shreg[DATA_W-1:1]};
                            if (bitn == BW'(DATA_W - 1))
                                state <= (PARITY_EN != 0) ? SER_PAR : SER_STOP;
                            else
                                bitn <= bitn + 1'b1;
                        end
                        SER_PAR: begin
                            parbit <= line;
                            state  <= SER_STOP;
                        end
                        default: begin
                            done       <= 1'b1;
                            frame.data <= shreg;
                            frame.fe   <= !line;
                            frame.pe   <= (PARITY_EN != 0) && (parbit != even_par(shreg));
                            state      <= SER_IDLE;
                        end
                    endcase
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/uart_break_det.sv
module uart_break_det
    import uart_lsr_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int PARITY_EN = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic line,
    output logic brk_evt
);
    localparam int LIMIT = OVS * (DATA_W + 2 + ((PARITY_EN != 0) ? 1 : 0));
    localparam int BW    = $clog2(LIMIT + 2);

    logic [BW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            brk_evt <= 1'b0;
        end else begin
            brk_evt <= tick && !line && (low_cnt == BW'(LIMIT));
            if (line)
                low_cnt <= '0;
            else if (tick && (low_cnt != BW'(LIMIT + 1)))
                low_cnt <= low_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/uart_lsr_core.sv
module uart_lsr_core
    import uart_lsr_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int PARITY_EN   = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       baud_tick,
    input  logic [1:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       rx_in,
    output logic       tx_out,
    output logic       rts_n,
    output logic       dtr_n
);
    logic [7:0]        mcr_q;
    logic              thr_full_q;
    logic [DATA_W-1:0] thr_q;
    logic [DATA_W-1:0] rbr_q;
    logic              dr_q;
    err_flags_t        err_q, err_d;

    logic      tx_busy, tx_line, tx_load;
    logic      rx_done, brk_evt;
    rx_frame_t rx_frame;
    logic      loop_en, rx_src, rx_sync;
    logic      wr_data, wr_mcr, rd_data, rd_lsr;
    logic      temt, thre;
    logic [7:0] lsr_byte;

    assign loop_en = mcr_q[MCR_LOOP];
    assign wr_data = reg_wr && (reg_addr == ADDR_DATA);
    assign wr_mcr  = reg_wr && (reg_addr == ADDR_MCR);
    assign rd_data = reg_rd && (reg_addr == ADDR_DATA);
    assign rd_lsr  = reg_rd && (reg_addr == ADDR_LSR);
    assign tx_load = thr_full_q && !tx_busy;

    // Serial input path: loopback select, then resynchronisation
    assign rx_src = loop_en ? tx_line : rx_in;

    logic [SYNC_STAGES-1:0] sync_q;
    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst)
                    sync_q[s] <= 1'b1;
                else if (s == 0)
                    sync_q[s] <= rx_src;
                else
                    sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate
    assign rx_sync = sync_q[SYNC_STAGES-1];

    uart_tx_engine #(.OVS(OVS), .PARITY_EN(PARITY_EN)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .tick      (baud_tick),
        .load      (tx_load),
        .load_data (thr_q),
        .busy      (tx_busy),
        .line      (tx_line)
    );

    uart_rx_engine #(.OVS(OVS), .PARITY_EN(PARITY_EN)) u_rx (
        .clk   (clk),
        .rst   (rst),
        .tick  (baud_tick),
        .line  (rx_sync),
        .done  (rx_done),
        .frame (rx_frame)
    );

    uart_break_det #(.OVS(OVS), .PARITY_EN(PARITY_EN)) u_brk (
        .clk     (clk),
        .rst     (rst),
        .tick    (baud_tick),
        .line    (rx_sync),
        .brk_evt (brk_evt)
    );

    // Error flags: read clears, a same-cycle event wins
    always_comb begin
        err_d = rd_lsr ? '0 : err_q;
        if (brk_evt)                            err_d.bi = 1'b1;
        if (rx_done && rx_frame.fe)             err_d.fe = 1'b1;
        if (rx_done && rx_frame.pe)             err_d.pe = 1'b1;
        if (rx_done && dr_q && !rd_data)        err_d.oe = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mcr_q      <= '0;
            thr_full_q <= 1'b0;
            thr_q      <= '0;
            rbr_q      <= '0;
            dr_q       <= 1'b0;
            err_q      <= '0;
        end else begin
            err_q <= err_d;
            if (wr_mcr)
                mcr_q <= reg_wdata & MCR_MASK;
            if (tx_load)
                thr_full_q <= 1'b0;
            if (wr_data) begin
                thr_full_q <= 1'b1;
                thr_q      <= reg_wdata;
            end
            if (rd_data)
                dr_q <= 1'b0;
            if (rx_done) begin
                dr_q  <= 1'b1;
                rbr_q <= rx_frame.data;
            end
        end
    end

    assign thre     = !thr_full_q;
    assign temt     = !thr_full_q && !tx_busy;
    assign lsr_byte = {1'b0, temt, thre, err_q.bi, err_q.fe, err_q.pe, err_q.oe, dr_q};

    always_comb begin
        case (reg_addr)
            ADDR_DATA: reg_rdata = rbr_q;
            ADDR_MCR:  reg_rdata = mcr_q;
            ADDR_LSR:  reg_rdata = lsr_byte;
            default:   reg_rdata = 8'h00;
        endcase
    end

    assign tx_out = loop_en ? 1'b1 : tx_line;
    assign rts_n  = !mcr_q[MCR_RTS];
    assign dtr_n  = !mcr_q[MCR_DTR];

endmodule

// File: rtl/uart_lsr_checker.sv
module uart_lsr_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] reg_addr,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [1:0] hs_wbits,
    input logic       tx_out,
    input logic       rts_n,
    input logic       dtr_n,
    input logic       loop_en,
    input logic       thr_full_q,
    input logic       tx_busy,
    input logic       dr_q,
    input logic [3:0] err_q,
    input logic       rx_done,
    input logic       rx_fe,
    input logic       brk_evt
);
    // err_q bit order: [3] break, [2] framing, [1] parity, [0] overrun

    a_r6_loop_line_high: assert property (@(posedge clk) disable iff (rst)
        loop_en |-> tx_out);

    a_r5_idle_line_high: assert property (@(posedge clk) disable iff (rst)
        (!thr_full_q && !tx_busy) |-> tx_out);

    a_r2_handshake_follow: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd1) |=>
            (rts_n == !$past(hs_wbits[1]) && dtr_n == !$past(hs_wbits[0])));

    a_r4_write_fills_holding: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd0) |=> thr_full_q);

    a_r7_done_sets_ready: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> dr_q);

    a_r8_read_clears_ready: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 2'd0 && !rx_done) |=> !dr_q);

    a_r9_overrun_flag: assert property (@(posedge clk) disable iff (rst)
        (rx_done && dr_q && !(reg_rd && reg_addr == 2'd0)) |=> err_q[0]);

    a_r10_framing_flag: assert property (@(posedge clk) disable iff (rst)
        (rx_done && rx_fe) |=> err_q[2]);

    a_r11_break_flag: assert property (@(posedge clk) disable iff (rst)
        brk_evt |=> err_q[3]);

    a_r12_read_clears_errors: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 2'd2 && !rx_done && !brk_evt) |=> (err_q == 4'h0));

    a_r12_event_beats_read: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 2'd2 && rx_done && rx_fe) |=> err_q[2]);

endmodule

bind uart_lsr_core uart_lsr_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .hs_wbits   (reg_wdata[1:0]),
    .tx_out     (tx_out),
    .rts_n      (rts_n),
    .dtr_n      (dtr_n),
    .loop_en    (mcr_q[4]),
    .thr_full_q (thr_full_q),
    .tx_busy    (tx_busy),
    .dr_q       (dr_q),
    .err_q      (err_q),
    .rx_done    (rx_done),
    .rx_fe      (rx_frame.fe),
    .brk_evt    (brk_evt)
);

// File: tb/tb_uart_lsr_core.sv
module tb_uart_lsr_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       rx_in = 1'b1;
    logic       tx_out, rts_n, dtr_n;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    uart_lsr_core dut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_in(rx_in), .tx_out(tx_out), .rts_n(rts_n), .dtr_n(dtr_n)
    );

    always #10 clk = ~clk;

    // One tick every four clocks
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv = (tdiv + 1) % 4;
        baud_tick <= (tdiv == 3);
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
        end
    endtask

    // Behavioural transmit and modem-control model
    bit   m_thr_full;
    byte  m_thr;
    bit   m_q[$];
    int   m_ticks;
    bit   m_line = 1'b1;
    byte  m_mcr;

    always @(posedge clk) begin
        if (rst) begin
            m_thr_full = 0; m_thr = 0; m_q.delete(); m_ticks = 0; m_line = 1; m_mcr = 0;
        end else begin
            if (m_q.size() > 0) begin
                if (baud_tick) begin
                    m_ticks++;
                    if (m_ticks == 16) begin
                        m_ticks = 0;
                        void'(m_q.pop_front());
                        m_line = (m_q.size() > 0) ? m_q[0] : 1'b1;
                    end
                end
            end else if (m_thr_full) begin
                m_q.push_back(1'b0);
                for (int i = 0; i < 8; i++) m_q.push_back(m_thr[i]);
                m_q.push_back(^m_thr);
                m_q.push_back(1'b1);
                m_thr_full = 0;
                m_line = 1'b0;
                m_ticks = 0;
            end
            if (reg_wr && reg_addr == 2'd0) begin m_thr_full = 1; m_thr = reg_wdata; end
            if (reg_wr && reg_addr == 2'd1) m_mcr = reg_wdata & 8'h13;
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            bit exp_tx;
            exp_tx = m_mcr[4] ? 1'b1 : m_line;
            check(tx_out == exp_tx, "R5/R6 tx_out per clock", tx_out, exp_tx);
            check(rts_n == !m_mcr[1], "R2 rts_n per clock", rts_n, !m_mcr[1]);
            check(dtr_n == !m_mcr[0], "R2 dtr_n per clock", dtr_n, !m_mcr[0]);
        end
    end

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * 4) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] b, input bit bad_par, input bit bad_stop);
        @(negedge clk);
        rx_in = 1'b0; wait_ticks(16);
        for (int i = 0; i < 8; i++) begin rx_in = b[i]; wait_ticks(16); end
        rx_in = (^b) ^ bad_par; wait_ticks(16);
        if (bad_stop) begin
            rx_in = 1'b0; wait_ticks(12); rx_in = 1'b1; wait_ticks(4);
        end else begin
            rx_in = 1'b1; wait_ticks(16);
        end
        wait_ticks(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // Reset state
        do_read(2'd2, v); check(v == 8'h60, "R3 line status after reset", v, 8'h60);
        do_read(2'd1, v); check(v == 8'h00, "R1 modem control after reset", v, 8'h00);
        check(rts_n && dtr_n, "R2 handshake outputs after reset", {rts_n, dtr_n}, 2'b11);
        do_read(2'd3, v); check(v == 8'h00, "R1 unused address reads zero", v, 8'h00);

        // Modem control storage and handshake outputs
        do_write(2'd1, 8'hEF);
        do_read(2'd1, v); check(v == 8'h03, "R1 reserved bits dropped", v, 8'h03);
        check(!rts_n && !dtr_n, "R2 handshake asserted", {rts_n, dtr_n}, 2'b00);
        do_write(2'd1, 8'h02);
        check(!rts_n && dtr_n, "R2 only rts asserted", {rts_n, dtr_n}, 2'b01);

        // Transmit: single byte
        do_write(2'd0, 8'hA5);
        do_read(2'd2, v); check(v == 8'h20, "R4 holding free, shifter busy", v, 8'h20);
        wait_ticks(190);
        do_read(2'd2, v); check(v == 8'h60, "R4 transmitter drained", v, 8'h60);

        // Transmit: back-to-back bytes
        do_write(2'd0, 8'h01);
        do_write(2'd0, 8'hFE);
        do_read(2'd2, v); check(v == 8'h00, "R4 holding and shifter both full", v, 8'h00);
        wait_ticks(380);
        do_read(2'd2, v); check(v == 8'h60, "R4 both bytes sent", v, 8'h60);

        // Receive: clean byte
        send_rx(8'h3C, 0, 0);
        do_read(2'd2, v); check(v == 8'h61, "R7 data ready after clean frame", v, 8'h61);
        do_read(2'd0, v); check(v == 8'h3C, "R7 received byte", v, 8'h3C);
        do_read(2'd2, v); check(v == 8'h60, "R8 data ready cleared by buffer read", v, 8'h60);

        // Receive: parity error
        send_rx(8'h96, 1, 0);
        do_read(2'd2, v); check(v == 8'h65, "R10 parity error flagged", v, 8'h65);
        do_read(2'd2, v); check(v == 8'h61, "R12 parity flag cleared by status read", v, 8'h61);
        do_read(2'd0, v); check(v == 8'h96, "R10 byte kept despite parity error", v, 8'h96);

        // Receive: invalid stop bit
        send_rx(8'h81, 0, 1);
        wait_ticks(20);
        do_read(2'd2, v); check(v == 8'h69, "R10 framing error flagged", v, 8'h69);
        do_read(2'd0, v); check(v == 8'h81, "R7 byte with framing error", v, 8'h81);
        do_read(2'd2, v); check(v == 8'h60, "R12 framing flag cleared", v, 8'h60);

        // Receive: overrun
        send_rx(8'h11, 0, 0);
        send_rx(8'h7E, 0, 0);
        do_read(2'd2, v); check(v == 8'h63, "R9 overrun flagged", v, 8'h63);
        do_read(2'd0, v); check(v == 8'h7E, "R9 buffer holds newer byte", v, 8'h7E);
        do_read(2'd2, v); check(v == 8'h60, "R12 overrun flag cleared", v, 8'h60);

        // Break
        @(negedge clk); rx_in = 1'b0;
        wait_ticks(200);
        rx_in = 1'b1;
        wait_ticks(200);
        do_read(2'd2, v); check(v[4] == 1'b1, "R11 break flagged", v[4], 1);
        do_read(2'd2, v); check((v & 8'h1E) == 8'h00, "R12 errors cleared after break", v & 8'h1E, 0);
        do_read(2'd0, v);
        do_read(2'd2, v); check(v == 8'h60, "R8 status clean after break", v, 8'h60);

        // Short low pulse: no start confirmed
        @(negedge clk); rx_in = 1'b0; wait_ticks(3); rx_in = 1'b1;
        wait_ticks(200);
        do_read(2'd2, v); check(v == 8'h60, "R7 false start rejected", v, 8'h60);

        // Loopback with rx_in held low
        do_write(2'd1, 8'h10);
        @(negedge clk); rx_in = 1'b0;
        do_write(2'd0, 8'h5A);
        wait_ticks(200);
        do_read(2'd2, v); check(v == 8'h61, "R6 loopback byte received without errors", v, 8'h61);
        do_read(2'd0, v); check(v == 8'h5A, "R6 loopback data", v, 8'h5A);
        @(negedge clk); rx_in = 1'b1;
        wait_ticks(4);
        do_write(2'd1, 8'h00);
        wait_ticks(20);
        do_read(2'd2, v); check(v == 8'h60, "R6 clean exit from loopback", v, 8'h60);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule